// File: doc/BRIEF.md
# Double-Width Unsigned Divider

This unit divides a dividend of twice the word width by a single-word divisor and returns a one-word quotient, a one-word remainder and an overflow flag. The dividend is assembled from two operand words: a high word and a low word. The divisor is a third word, zero-extended to double width. A caller presents the three operands together with a one-cycle start request. It then waits for a one-cycle done pulse, and the results stay on the outputs until the next accepted request.

Before any iteration, the unit decides whether the quotient can fit in one word. It can fit only when the high word is unsigned-smaller than the divisor, and that condition also rules out a zero divisor. When the quotient cannot fit, the unit skips the division. It reports saturated results in the cycle after the request. Otherwise a restoring radix-2 datapath produces one quotient bit per clock, for as many clocks as the word has bits.

Top module: `dw_div`

## Requirements
- R1: After reset, done_o, busy_o and ovf_o are 0, and quo_o and rem_o are all zeros.
- R2: When hi_i < dsr_i (unsigned) and dsr_i is nonzero, the result has three parts. quo_o is the low W bits of {hi_i, lo_i} / dsr_i, with hi_i as the upper W bits. rem_o is the remainder of that division. ovf_o is 0.
- R3: When hi_i >= dsr_i or dsr_i is zero, the result is saturated: quo_o is all ones, rem_o is all zeros and ovf_o is 1.
- R4: An overflowing request raises done_o in the first cycle after it is accepted, and busy_o stays low throughout.
- R5: A non-overflowing request holds busy_o high for exactly W cycles. done_o rises W+1 cycles after the accepting clock edge.
- R6: start_i is ignored while busy_o is high. Operands or start pulses presented during that time do not change the result, its timing, or the number of done pulses.
- R7: done_o is high for a single cycle per accepted request. While the unit is idle and no start is applied, quo_o, rem_o and ovf_o do not change.
- R8: busy_o and done_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request; accepted when busy_o is low |
| lo_i | input | W | Low word of the dividend |
| hi_i | input | W | High word of the dividend |
| dsr_i | input | W | Divisor |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quo_o | output | W | Quotient (low W bits) |
| rem_o | output | W | Remainder |
| ovf_o | output | 1 | Quotient did not fit; saturated results |

## Verification
The bench builds the unit with its default width of 64. Each case is therefore compared against a full 128-bit reference division of {hi, lo} by the divisor. This also makes the 65-cycle latency visible, so that it can be counted cycle by cycle. The boundary operands are the ones at the edge of the fit test: a high word one below the divisor, a divisor of one, a high word equal to the divisor, and a zero divisor. Together they cover the quotient that just fits in a word, the quotient that is cut off, and the zero-divisor overflow.

// File: rtl/dw_div_pkg.sv
package dw_div_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } dw_state_e;
endpackage

// File: rtl/dw_div_ovf.sv
module dw_div_ovf #(
  parameter int W = 64
) (
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] dsr_i,
  output logic         ovf_o
);
  // quotient fits in W bits only when hi < divisor (this also excludes divisor 0)
  assign ovf_o = (dsr_i == '0) || (hi_i >= dsr_i);
endmodule

// File: rtl/dw_div_step.sv
module dw_div_step #(
  parameter int W = 64
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] dsr_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);
  logic [W:0]   trial;
  logic [W-1:0] diff;
  logic         ge;

  always_comb begin
    trial = {rem_i, quo_i[W-1]};
    ge    = trial >= {1'b0, dsr_i};
    // true difference is below the divisor, so W bits suffice
    diff  = trial[W-1:0] - dsr_i;
    rem_o = ge ? diff : trial[W-1:0];
    quo_o = {quo_i[W-2:0], ge};
  end
endmodule

// File: rtl/dw_div_ctrl.sv
module dw_div_ctrl
  import dw_div_pkg::*;
#(
  parameter int W = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ovf_i,
  output logic accept_o,
  output logic step_o,
  output logic last_o,
  output logic busy_o
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST_CNT = CW'(W - 1);

  dw_state_e      state_q;
  logic [CW-1:0]  cnt_q;

  assign busy_o   = (state_q == ST_RUN);
  assign accept_o = start_i && (state_q == ST_IDLE);
  assign step_o   = busy_o;
  assign last_o   = busy_o && (cnt_q == LAST_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept_o && !ovf_i) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (last_o) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dw_div.sv
module dw_div #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] dsr_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o,
  output logic         ovf_o
);
  logic         ovf;
  logic         accept, step, last;
  logic [W-1:0] rem_q, quo_q, dsr_q;
  logic [W-1:0] rem_nx, quo_nx;
  logic         ovf_q, done_q;

  dw_div_ovf #(.W(W)) u_ovf (
    .hi_i  (hi_i),
    .dsr_i (dsr_i),
    .ovf_o (ovf)
  );

  dw_div_ctrl #(.W(W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .ovf_i    (ovf),
    .accept_o (accept),
    .step_o   (step),
    .last_o   (last),
    .busy_o   (busy_o)
  );

  dw_div_step #(.W(W)) u_step (
    .rem_i (rem_q),
    .quo_i (quo_q),
    .dsr_i (dsr_q),
    .rem_o (rem_nx),
    .quo_o (quo_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dsr_q  <= '0;
      ovf_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        if (ovf) begin
          quo_q  <= '1;
          rem_q  <= '0;
          ovf_q  <= 1'b1;
          done_q <= 1'b1;
        end else begin
          rem_q <= hi_i;
          quo_q <= lo_i;
          dsr_q <= dsr_i;
          ovf_q <= 1'b0;
        end
      end else if (step) begin
        rem_q <= rem_nx;
        quo_q <= quo_nx;
        if (last) done_q <= 1'b1;
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;
  assign rem_o  = rem_q;
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/dw_div_chk.sv
module dw_div_chk #(
  parameter int W = 64
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [W-1:0] hi_i,
  input logic [W-1:0] dsr_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] quo_o,
  input logic [W-1:0] rem_o,
  input logic         ovf_o
);
  p_sat_vals_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ovf_o) |-> (quo_o == '1 && rem_o == '0));

  p_ovf_fast_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && (dsr_i == '0 || hi_i >= dsr_i)) |=> (done_o && ovf_o && !busy_o));

  p_run_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && dsr_i != '0 && hi_i < dsr_i) |=> (busy_o && !done_o));

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !done_o);

  p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(quo_o) && $stable(rem_o) && $stable(ovf_o)));

  p_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
endmodule

bind dw_div dw_div_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .hi_i    (hi_i),
  .dsr_i   (dsr_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .quo_o   (quo_o),
  .rem_o   (rem_o),
  .ovf_o   (ovf_o)
);

// File: tb/sim_dw_div.sv
module sim_dw_div;
  localparam int W = 64;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [W-1:0] lo_i = '0, hi_i = '0, dsr_i = '0;
  logic         busy_o, done_o, ovf_o;
  logic [W-1:0] quo_o, rem_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;  // 20 ns period, 50 MHz

  dw_div #(.W(W)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .lo_i(lo_i), .hi_i(hi_i), .dsr_i(dsr_i),
    .busy_o(busy_o), .done_o(done_o), .quo_o(quo_o), .rem_o(rem_o), .ovf_o(ovf_o)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(done_o == 1'b0 && busy_o == 1'b0 && ovf_o == 1'b0, "R1 flags", {done_o, busy_o, ovf_o}, 0);
    chk(quo_o == '0 && rem_o == '0, "R1 data", {quo_o, rem_o}, 0);
  endtask

  // one request; checks values, latency, busy behaviour and the done pulse width
  task automatic t_run(input logic [W-1:0] c, input logic [W-1:0] a, input logic [W-1:0] b,
                       input bit noise);
    logic [127:0] dd, dv, eq, er;
    bit ov;
    int n, exp_lat, busy_cnt;
    ov = (b == '0) || (c >= b);
    dd = {c, a};
    dv = {64'd0, b};
    if (!ov) begin eq = dd / dv; er = dd % dv; end
    else begin eq = {64'd0, {W{1'b1}}}; er = '0; end
    exp_lat = ov ? 1 : W + 1;
    @(negedge clk_i);
    hi_i = c; lo_i = a; dsr_i = b; start_i = 1'b1;
    n = 0; busy_cnt = 0;
    do begin
      @(negedge clk_i);
      n++;
      start_i = 1'b0;
      if (noise && n >= 3 && n <= 6) begin
        // R6: disturbing requests while busy
        start_i = 1'b1; hi_i = '1; lo_i = '0; dsr_i = '0;
      end
      if (busy_o) busy_cnt++;
    end while (!done_o && n < 200);
    start_i = 1'b0;
    if (ov) begin
      chk(n == exp_lat, "R4 latency", n, exp_lat);
      chk(busy_cnt == 0, "R4 busy low", busy_cnt, 0);
      chk(quo_o == eq[W-1:0] && rem_o == er[W-1:0] && ovf_o, "R3 saturate",
          {quo_o, rem_o}, {eq[W-1:0], er[W-1:0]});
    end else begin
      chk(n == exp_lat, noise ? "R6 latency" : "R5 latency", n, exp_lat);
      chk(busy_cnt == W, "R5 busy cycles", busy_cnt, W);
      chk(quo_o == eq[W-1:0], noise ? "R6 quotient" : "R2 quotient", quo_o, eq[W-1:0]);
      chk(rem_o == er[W-1:0], noise ? "R6 remainder" : "R2 remainder", rem_o, er[W-1:0]);
      chk(ovf_o == 1'b0, "R2 ovf", ovf_o, 0);
    end
    chk(!(busy_o && done_o), "R8 exclusive", {busy_o, done_o}, 0);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R7 pulse", done_o, 0);
    if (noise) chk(busy_o == 1'b0, "R6 no restart", busy_o, 0);
  endtask

  task automatic t_hold();
    logic [W-1:0] q, r;
    logic o;
    q = quo_o; r = rem_o; o = ovf_o;
    hi_i = 64'h5; lo_i = 64'h77; dsr_i = 64'h3;
    repeat (5) begin
      @(negedge clk_i);
      chk(quo_o == q && rem_o == r && ovf_o == o, "R7 hold", {quo_o, rem_o}, {q, r});
      chk(done_o == 1'b0, "R7 no done", done_o, 0);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired act=hung exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_run(64'd0, 64'd100, 64'd7, 1'b0);
    t_run(64'h0000_0000_0000_0002, 64'h1234_5678_9abc_def0, 64'h0000_0000_0000_0003, 1'b0);
    t_run(64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0); // C = B-1
    t_run(64'd0, 64'hDEAD_BEEF_0BAD_F00D, 64'd1, 1'b0);      // B = 1
    t_run(64'd1, 64'd5, 64'd1, 1'b0);                        // B = 1, overflow
    t_run(64'd9, 64'd5, 64'd9, 1'b0);                        // C = B
    t_run(64'd0, 64'd5, 64'd0, 1'b0);                        // B = 0
    t_run(64'h10, 64'h3, 64'h2, 1'b0);                       // C > B
    t_hold();
    t_run(64'h3, 64'hCAFE, 64'h11, 1'b1);
    t_hold();
    for (int i = 0; i < 24; i++) begin
      logic [W-1:0] c, a, b;
      c = {$urandom, $urandom}; a = {$urandom, $urandom}; b = {$urandom, $urandom};
      if (i % 3 != 0 && b != '0) c = c % b;
      t_run(c, a, b, 1'b0);
    end
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule